// File: doc/BRIEF.md
# RV32I Instruction Decoder

This block turns one 32-bit base-integer instruction word into the control and operand information that a single-cycle core needs in the same cycle. It pulls out the two source register addresses and the destination address. It builds a sign-extended immediate in the layout the instruction format calls for. It also chooses where each ALU operand comes from, decides whether the register file or data memory is written or read, and picks the value that is written back. It holds no state. Every output follows the instruction input with no clock in the path.

Loads, register-immediate ALU operations, stores, register-register ALU operations, LUI, AUIPC, conditional branches, JAL and JALR are recognised. Branch resolution, the register file, the ALU and system instructions are outside this block. LUI goes down the ordinary add path: source register 1 is forced to x0 and the upper immediate is added to it. No separate bypass is needed.

Top module: `rv32i_decoder`

## Requirements
- R1: `rs2_addr_o` is always instruction bits 24..20 and `rd_addr_o` is always bits 11..7. `rs1_addr_o` is bits 19..15 for every opcode except LUI.
- R2: Opcode 0110111 (LUI) gives `rs1_addr_o`=0, immediate {bits 31..12, twelve zeros}, `op1_sel_o`=0, `op2_sel_o`=1, `reg_we_o`=1, both memory enables 0 and `wb_sel_o`=0. For example, 0x000022b7 gives immediate 0x00002000 and rd=5.
- R3: Opcode 0100011 (store) gives the immediate {bit 31 repeated 21 times, bits 30..25, bits 11..7}, `op1_sel_o`=0, `op2_sel_o`=1, `mem_we_o`=1, `mem_re_o`=0 and `reg_we_o`=0. For example, 0x00a02223 gives immediate 4, rs1=0 and rs2=10.
- R4: Opcode 0110011 (register-register) gives both operand selects 0, `reg_we_o`=1, immediate 0, both memory enables 0 and `wb_sel_o`=0. For example, 0x002081b3 gives rs1=1, rs2=2 and rd=3.
- R5: Opcodes 0010011 (register-immediate) and 0000011 (load) give the immediate bits 31..20 sign-extended from bit 31, `op1_sel_o`=0, `op2_sel_o`=1 and `reg_we_o`=1. A load also sets `mem_re_o`=1 and `wb_sel_o`=1. The register-immediate opcode keeps `mem_re_o`=0 and `wb_sel_o`=0.
- R6: Opcode 1100011 (branch) gives the immediate {bit 31 repeated 20 times, bit 7, bits 30..25, bits 11..8, 0}, `op1_sel_o`=1, `op2_sel_o`=1, and all three enables 0.
- R7: Opcode 1101111 (JAL) gives the immediate {bit 31 repeated 12 times, bits 19..12, bit 20, bits 30..21, 0} with `op1_sel_o`=1. Opcode 1100111 (JALR) gives the I immediate with `op1_sel_o`=0. Both set `op2_sel_o`=1, `reg_we_o`=1, both memory enables 0 and `wb_sel_o`=2.
- R8: Opcode 0010111 (AUIPC) gives the U immediate, `op1_sel_o`=1, `op2_sel_o`=1, `reg_we_o`=1, both memory enables 0 and `wb_sel_o`=0.
- R9: Any other opcode gives `reg_we_o`=0, `mem_re_o`=0, `mem_we_o`=0, immediate 0, both operand selects 0 and `wb_sel_o`=0.
- R10: The encodings are as follows. `op1_sel_o` 0 means register and 1 means instruction address. `op2_sel_o` 0 means register and 1 means immediate. `wb_sel_o` 0 means ALU result, 1 means memory data and 2 means PC+4.
- R11: The decoder is purely combinational: outputs settle on a new instruction word without any clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| instr_i | input | 32 | Instruction word to decode |
| rs1_addr_o | output | 5 | Source register 1 read address |
| rs2_addr_o | output | 5 | Source register 2 read address |
| rd_addr_o | output | 5 | Destination register address |
| imm_o | output | XLEN | Sign-extended immediate |
| op1_sel_o | output | 1 | ALU operand 1 source: 0 register, 1 instruction address |
| op2_sel_o | output | 1 | ALU operand 2 source: 0 register, 1 immediate |
| reg_we_o | output | 1 | Register file write enable |
| mem_re_o | output | 1 | Data memory read enable |
| mem_we_o | output | 1 | Data memory write enable |
| wb_sel_o | output | 2 | Write-back source: 0 ALU, 1 memory, 2 PC+4 |

## Verification
The bench builds the decoder with the default XLEN of 32. This is the width at which every sign-extension boundary of the I, S, B, U and J immediates lands on real output bits. Random words drawn around the nine recognised opcodes and a handful of illegal ones exercise every immediate bit position under both sign polarities. Directed words pin the given store, LUI and add encodings, plus the most negative branch and jump offsets.

// File: rtl/rvdec_pkg.sv
package rvdec_pkg;

    localparam int ILEN   = 32;
    localparam int REG_AW = 5;
    localparam int OPC_W  = 7;

    localparam logic [OPC_W-1:0] OPC_LOAD   = 7'b0000011;
    localparam logic [OPC_W-1:0] OPC_OPIMM  = 7'b0010011;
    localparam logic [OPC_W-1:0] OPC_AUIPC  = 7'b0010111;
    localparam logic [OPC_W-1:0] OPC_STORE  = 7'b0100011;
    localparam logic [OPC_W-1:0] OPC_OP     = 7'b0110011;
    localparam logic [OPC_W-1:0] OPC_LUI    = 7'b0110111;
    localparam logic [OPC_W-1:0] OPC_BRANCH = 7'b1100011;
    localparam logic [OPC_W-1:0] OPC_JALR   = 7'b1100111;
    localparam logic [OPC_W-1:0] OPC_JAL    = 7'b1101111;

    typedef enum logic [2:0] {
        FMT_NONE = 3'd0,
        FMT_I    = 3'd1,
        FMT_S    = 3'd2,
        FMT_B    = 3'd3,
        FMT_U    = 3'd4,
        FMT_J    = 3'd5
    } fmt_e;

    typedef enum logic [1:0] {
        WB_ALU = 2'd0,
        WB_MEM = 2'd1,
        WB_PC4 = 2'd2
    } wb_e;

    typedef struct packed {
        fmt_e fmt;
        logic op1_pc;
        logic op2_imm;
        logic reg_we;
        logic mem_re;
        logic mem_we;
        wb_e  wb;
        logic zero_rs1;
    } ctrl_t;

endpackage

// File: rtl/rvdec_ctrl.sv
module rvdec_ctrl
    import rvdec_pkg::*;
(
    input  logic [OPC_W-1:0] opcode_i,
    output ctrl_t            ctrl_o
);

    ctrl_t ctrl_d;

    always_comb begin
        ctrl_d          = '0;
        ctrl_d.fmt      = FMT_NONE;
        ctrl_d.wb       = WB_ALU;
        unique case (opcode_i)
            OPC_LOAD: begin
                ctrl_d.fmt     = FMT_I;
                ctrl_d.op2_imm = 1'b1;
                ctrl_d.reg_we  = 1'b1;
                ctrl_d.mem_re  = 1'b1;
                ctrl_d.wb      = WB_MEM;
            end
            OPC_OPIMM: begin
                ctrl_d.fmt     = FMT_I;
                ctrl_d.op2_imm = 1'b1;
                ctrl_d.reg_we  = 1'b1;
            end
            OPC_AUIPC: begin
                ctrl_d.fmt     = FMT_U;
                ctrl_d.op1_pc  = 1'b1;
                ctrl_d.op2_imm = 1'b1;
                ctrl_d.reg_we  = 1'b1;
            end
            OPC_STORE: begin
                ctrl_d.fmt     = FMT_S;
                ctrl_d.op2_imm = 1'b1;
                ctrl_d.mem_we  = 1'b1;
            end
            OPC_OP: begin
                ctrl_d.reg_we  = 1'b1;
            end
            OPC_LUI: begin
                ctrl_d.fmt      = FMT_U;
                ctrl_d.op2_imm  = 1'b1;
                ctrl_d.reg_we   = 1'b1;
                ctrl_d.zero_rs1 = 1'b1;
            end
            OPC_BRANCH: begin
                ctrl_d.fmt     = FMT_B;
                ctrl_d.op1_pc  = 1'b1;
                ctrl_d.op2_imm = 1'b1;
            end
            OPC_JALR: begin
                ctrl_d.fmt     = FMT_I;
                ctrl_d.op2_imm = 1'b1;
                ctrl_d.reg_we  = 1'b1;
                ctrl_d.wb      = WB_PC4;
            end
            OPC_JAL: begin
                ctrl_d.fmt     = FMT_J;
                ctrl_d.op1_pc  = 1'b1;
                ctrl_d.op2_imm = 1'b1;
                ctrl_d.reg_we  = 1'b1;
                ctrl_d.wb      = WB_PC4;
            end
            default: begin
                ctrl_d = ctrl_d;
            end
        endcase
    end

    assign ctrl_o = ctrl_d;

    // Memory is never read and written by one instruction, and a store writes no register.
    always_comb begin
        if (!$isunknown(opcode_i)) begin
            p_store_excl_r3: assert (!ctrl_o.mem_we || (!ctrl_o.reg_we && !ctrl_o.mem_re))
                else $error("store drives another enable");
            p_load_wb_r5: assert (!ctrl_o.mem_re || (ctrl_o.wb == WB_MEM && ctrl_o.reg_we))
                else $error("load without memory write-back");
            p_pc4_we_r7: assert (ctrl_o.wb != WB_PC4 || ctrl_o.reg_we)
                else $error("link result without register write");
        end
    end

endmodule

// File: rtl/rvdec_immgen.sv
module rvdec_immgen
    import rvdec_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic [ILEN-1:7] ins_i,
    input  fmt_e            fmt_i,
    output logic [XLEN-1:0] imm_o
);

    localparam int EXT_I = XLEN - 12;
    localparam int EXT_B = XLEN - 12;
    localparam int EXT_U = XLEN - 32;
    localparam int EXT_J = XLEN - 20;

    logic [XLEN-1:0] imm_d;
    logic            sgn;

    assign sgn = ins_i[31];

    always_comb begin
        unique case (fmt_i)
            FMT_I:   imm_d = {{EXT_I{sgn}}, ins_i[31:20]};
            FMT_S:   imm_d = {{EXT_I{sgn}}, ins_i[31:25], ins_i[11:7]};
            FMT_B:   imm_d = {{EXT_B{sgn}}, ins_i[7], ins_i[30:25], ins_i[11:8], 1'b0};
            FMT_U:   imm_d = {{(EXT_U + 1){sgn}}, ins_i[30:12], 12'b0};
            FMT_J:   imm_d = {{EXT_J{sgn}}, ins_i[19:12], ins_i[20], ins_i[30:21], 1'b0};
            default: imm_d = '0;
        endcase
    end

    assign imm_o = imm_d;

    // Branch and jump offsets are always even; format-less words carry no immediate.
    always_comb begin
        if (!$isunknown({ins_i, fmt_i})) begin
            p_imm_even_r6: assert (!(fmt_i == FMT_B || fmt_i == FMT_J) || !imm_o[0])
                else $error("odd branch or jump offset");
            p_imm_none_r9: assert (fmt_i != FMT_NONE || imm_o == '0)
                else $error("immediate without format");
            p_imm_sign_r5: assert (fmt_i == FMT_NONE || imm_o[XLEN-1] == ins_i[31])
                else $error("immediate sign not from bit 31");
        end
    end

endmodule

// File: rtl/rvdec_fields.sv
module rvdec_fields
    import rvdec_pkg::*;
(
    input  logic [REG_AW-1:0] rs1_raw_i,
    input  logic [REG_AW-1:0] rs2_raw_i,
    input  logic [REG_AW-1:0] rd_raw_i,
    input  logic              zero_rs1_i,
    output logic [REG_AW-1:0] rs1_o,
    output logic [REG_AW-1:0] rs2_o,
    output logic [REG_AW-1:0] rd_o
);

    logic [REG_AW-1:0] rs1_d;

    always_comb begin
        rs1_d = zero_rs1_i ? '0 : rs1_raw_i;
    end

    assign rs1_o = rs1_d;
    assign rs2_o = rs2_raw_i;
    assign rd_o  = rd_raw_i;

endmodule

// File: rtl/rv32i_decoder.sv
module rv32i_decoder
    import rvdec_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic [31:0]     instr_i,
    output logic [4:0]      rs1_addr_o,
    output logic [4:0]      rs2_addr_o,
    output logic [4:0]      rd_addr_o,
    output logic [XLEN-1:0] imm_o,
    output logic            op1_sel_o,
    output logic            op2_sel_o,
    output logic            reg_we_o,
    output logic            mem_re_o,
    output logic            mem_we_o,
    output logic [1:0]      wb_sel_o
);

    ctrl_t ctrl;

    rvdec_ctrl u_ctrl (
        .opcode_i (instr_i[OPC_W-1:0]),
        .ctrl_o   (ctrl)
    );

    rvdec_immgen #(.XLEN(XLEN)) u_immgen (
        .ins_i (instr_i[31:7]),
        .fmt_i (ctrl.fmt),
        .imm_o (imm_o)
    );

    rvdec_fields u_fields (
        .rs1_raw_i  (instr_i[19:15]),
        .rs2_raw_i  (instr_i[24:20]),
        .rd_raw_i   (instr_i[11:7]),
        .zero_rs1_i (ctrl.zero_rs1),
        .rs1_o      (rs1_addr_o),
        .rs2_o      (rs2_addr_o),
        .rd_o       (rd_addr_o)
    );

    assign op1_sel_o = ctrl.op1_pc;
    assign op2_sel_o = ctrl.op2_imm;
    assign reg_we_o  = ctrl.reg_we;
    assign mem_re_o  = ctrl.mem_re;
    assign mem_we_o  = ctrl.mem_we;
    assign wb_sel_o  = ctrl.wb;

    logic is_known;
    assign is_known = (instr_i[6:0] == OPC_LOAD)  || (instr_i[6:0] == OPC_OPIMM)
                   || (instr_i[6:0] == OPC_AUIPC) || (instr_i[6:0] == OPC_STORE)
                   || (instr_i[6:0] == OPC_OP)    || (instr_i[6:0] == OPC_LUI)
                   || (instr_i[6:0] == OPC_BRANCH)|| (instr_i[6:0] == OPC_JALR)
                   || (instr_i[6:0] == OPC_JAL);

    always_comb begin
        if (!$isunknown(instr_i)) begin
            p_lui_rs1_zero_r2: assert (instr_i[6:0] != OPC_LUI || rs1_addr_o == 5'd0)
                else $error("LUI does not read x0");
            p_rs1_pass_r1: assert (instr_i[6:0] == OPC_LUI || rs1_addr_o == instr_i[19:15])
                else $error("rs1 field altered");
            p_unknown_quiet_r9: assert (is_known || !(reg_we_o || mem_re_o || mem_we_o))
                else $error("illegal opcode raises an enable");
            p_wb_legal_r10: assert (wb_sel_o != 2'd3)
                else $error("reserved write-back code");
        end
    end

endmodule

// File: tb/rv32i_decoder_bench.sv
module rv32i_decoder_bench;

    localparam int XLEN = 32;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic [31:0]     instr;
    logic [4:0]      rs1, rs2, rd;
    logic [XLEN-1:0] imm;
    logic            op1, op2, rwe, mre, mwe;
    logic [1:0]      wb;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    rv32i_decoder #(.XLEN(XLEN)) u_rv32i_decoder (
        .instr_i    (instr),
        .rs1_addr_o (rs1),
        .rs2_addr_o (rs2),
        .rd_addr_o  (rd),
        .imm_o      (imm),
        .op1_sel_o  (op1),
        .op2_sel_o  (op2),
        .reg_we_o   (rwe),
        .mem_re_o   (mre),
        .mem_we_o   (mwe),
        .wb_sel_o   (wb)
    );

    // Packed expectation: {rs1, rs2, rd, imm, op1, op2, rwe, mre, mwe, wb}
    function automatic logic [53:0] model(input logic [31:0] w);
        logic [31:0] ii, is, ib, iu, ij, im;
        logic [4:0]  r1;
        logic        a, b, we, re, me;
        logic [1:0]  s;
        ii = {{20{w[31]}}, w[31:20]};
        is = {{20{w[31]}}, w[31:25], w[11:7]};
        ib = {{19{w[31]}}, w[31], w[7], w[30:25], w[11:8], 1'b0};
        iu = {w[31:12], 12'h000};
        ij = {{11{w[31]}}, w[31], w[19:12], w[20], w[30:21], 1'b0};
        r1 = w[19:15];
        {a, b, we, re, me, s, im} = '0;
        case (w[6:0])
            7'b0000011: begin im = ii; b = 1; we = 1; re = 1; s = 2'd1; end
            7'b0010011: begin im = ii; b = 1; we = 1; end
            7'b0010111: begin im = iu; a = 1; b = 1; we = 1; end
            7'b0100011: begin im = is; b = 1; me = 1; end
            7'b0110011: begin we = 1; end
            7'b0110111: begin im = iu; b = 1; we = 1; r1 = 5'd0; end
            7'b1100011: begin im = ib; a = 1; b = 1; end
            7'b1100111: begin im = ii; b = 1; we = 1; s = 2'd2; end
            7'b1101111: begin im = ij; a = 1; b = 1; we = 1; s = 2'd2; end
            default: ;
        endcase
        return {r1, w[24:20], w[11:7], im, a, b, we, re, me, s};
    endfunction

    function automatic string tag(input logic [6:0] op);
        case (op)
            7'b0000011, 7'b0010011: return "R5";
            7'b0010111: return "R8";
            7'b0100011: return "R3";
            7'b0110011: return "R4";
            7'b0110111: return "R2";
            7'b1100011: return "R6";
            7'b1100111, 7'b1101111: return "R7";
            default:    return "R9";
        endcase
    endfunction

    function automatic logic [53:0] actual();
        return {rs1, rs2, rd, imm, op1, op2, rwe, mre, mwe, wb};
    endfunction

    // Drive at the falling edge, sample 1 ns later with no clock edge between (R11).
    task automatic apply(input logic [31:0] w);
        @(negedge clk);
        instr = w;
        #1;
    endtask

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s instr=%h actual=%h expected=%h", req, instr, act, exp);
        end
    endtask

    // Full-vector check against the model; also tags R1, R10 and R11.
    task automatic vec(input logic [31:0] w);
        apply(w);
        chk({tag(w[6:0]), "/R1/R10/R11"}, 64'(actual()), 64'(model(w)));
    endtask

    localparam logic [6:0] OPS [0:12] = '{7'b0000011, 7'b0010011, 7'b0010111, 7'b0100011,
                                          7'b0110011, 7'b0110111, 7'b1100011, 7'b1100111,
                                          7'b1101111, 7'b1110011, 7'b0001111, 7'b1111111,
                                          7'b0000000};

    initial begin
        instr = 32'h0;
        #1;
        // Reset-like all-zero word: illegal opcode, everything quiet (R9).
        apply(32'h0000_0000);
        chk("R9", {61'd0, rwe, mre, mwe}, 64'd0);
        chk("R9", 64'(imm), 64'd0);

        // Store word: imm 4, rs1 0, rs2 10 (R3).
        apply(32'h00a0_2223);
        chk("R3", 64'(imm), 64'd4);
        chk("R1", {54'd0, rs1, rs2}, {54'd0, 5'd0, 5'd10});
        chk("R3", {59'd0, op1, op2, rwe, mre, mwe}, {59'd0, 5'b01001});

        // LUI: imm 0x2000, rd 5, rs1 forced 0 (R2).
        apply(32'h0000_22b7);
        chk("R2", 64'(imm), 64'h2000);
        chk("R2", {54'd0, rs1, rd}, {54'd0, 5'd0, 5'd5});
        chk("R2", {57'd0, op1, op2, rwe, mre, mwe, wb}, {57'd0, 7'b0110000});
        apply(32'hfffff_0b7 | 32'h000f8000);
        chk("R2", {59'd0, rs1}, 64'd0);

        // add x3, x1, x2 (R4).
        apply(32'h0020_81b3);
        chk("R4", {49'd0, rs1, rs2, rd}, {49'd0, 5'd1, 5'd2, 5'd3});
        chk("R4", {59'd0, op1, op2, rwe, mre, mwe}, {59'd0, 5'b00100});

        // Most negative branch and jump offsets (R6, R7).
        apply(32'h8000_0063);
        chk("R6", 64'(imm), 64'(32'hFFFF_F000));
        apply(32'h8000_00ef);
        chk("R7", 64'(imm), 64'(32'hFFF0_0000));
        chk("R7", {62'd0, wb}, 64'd2);
        // Load with negative offset selects memory data (R5).
        apply(32'hfff0_2083);
        chk("R5", 64'(imm), 64'(32'hFFFF_FFFF));
        chk("R5", {61'd0, wb, mre}, {61'd0, 2'd1, 1'b1});
        // AUIPC (R8).
        apply(32'h8000_0017);
        chk("R8", {64'(imm)}, 64'(32'h8000_0000));
        chk("R8", {62'd0, op1, op2}, 64'd3);

        // Random words around each opcode (fixed seed).
        void'($urandom(32'h5eed_1234));
        for (int i = 0; i < 600; i++) begin
            logic [31:0] w;
            w = $urandom;
            w[6:0] = OPS[$urandom_range(0, 12)];
            vec(w);
        end
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (100000) @(posedge clk);
                checks++;
                errors++;
                $display("FAIL watchdog expired");
            end
        join_any
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule